// File: doc/BRIEF.md
# Register Rename Unit with Retirement Map Recovery

This unit renames architectural registers to physical register tags for an out-of-order core in which results live only in a physical register file. It keeps a speculative map that dispatch reads and updates, a retirement map that only committing instructions update, and a bitmap of unallocated physical tags. Only tag bookkeeping is modelled here. The register file, the reorder buffer, the schedulers and the execution units are outside it.

At dispatch the unit takes two source register numbers and an optional destination. It returns the current physical tags of the sources, a freshly allocated destination tag and the tag that the destination mapped to before. At commit the reorder buffer presents the committing destination and its tag. The retirement map is written and the tag it held before goes back to the free pool. A flush request moves a two-state controller from `ST_RUN` to `ST_RECOVER`, on the transition `T_FLUSH`. During the single `ST_RECOVER` cycle the retirement map is copied over the whole speculative map and the free pool is rebuilt. The controller then returns to `ST_RUN` on `T_RESUME`, or stays in `ST_RECOVER` on `T_REFLUSH` if flush is still asserted.

Top module: `rn_rename`

## Requirements
- R1: After reset both maps send architectural register i to physical tag i, and the free pool holds exactly the tags NUM_ARCH..NUM_PHYS-1.
- R2: Source tags are read combinationally from the speculative map as it stood before this cycle's destination update. A source equal to the instruction's own destination gets the old tag, and the next instruction sees the new one.
- R3: A dispatch with a nonzero destination, while stall is low, returns the lowest-numbered free tag on dst_tag and the old mapping on prev_tag. It removes that tag from the pool and writes it into the speculative map at the clock edge.
- R4: A dispatch with disp_has_dst low, or with destination register 0, allocates nothing and drives dst_tag to 0.
- R5: Architectural register 0 always reads as tag 0, is never remapped, and tag 0 is never free.
- R6: stall is high whenever the free pool is empty, and no tag is allocated in a stalled cycle.
- R7: A commit of a nonzero destination writes the retirement map and returns the tag that map held before to the pool. That tag becomes allocatable in the following cycle, not in the commit cycle.
- R8: flush forces stall in its own cycle and in the following ST_RECOVER cycle. After that cycle the speculative map equals the retirement map, including any commit made in the ST_RECOVER cycle.
- R9: After recovery the free pool holds exactly the tags that no retirement map entry references.
- R10: A commit naming architectural register 0 changes neither map nor the free pool.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An instruction is offered for renaming |
| disp_src1 | input | AREG_W | First source register number |
| disp_src2 | input | AREG_W | Second source register number |
| disp_has_dst | input | 1 | Instruction writes a destination register |
| disp_dst | input | AREG_W | Destination register number |
| src1_tag | output | TAG_W | Physical tag of first source |
| src2_tag | output | TAG_W | Physical tag of second source |
| dst_tag | output | TAG_W | Newly allocated tag, 0 when nothing is allocated |
| prev_tag | output | TAG_W | Speculative mapping of disp_dst before this dispatch |
| stall | output | 1 | Dispatch is not accepted this cycle |
| ret_valid | input | 1 | An instruction commits |
| ret_dst | input | AREG_W | Committing destination register number |
| ret_tag | input | TAG_W | Committing destination's physical tag |
| flush | input | 1 | Squash all speculative state |

## Verification
The assertions take for granted that commits arrive in dispatch order and name only tags that dispatch actually allocated. In particular, a committed tag is never one the retirement map already holds and never one still in the free pool. The stimulus keeps to this by holding a model reorder queue in the bench: each allocation is pushed onto it, each commit pops its head, and a flush empties it. Random dispatch, commit and flush traffic is drawn only from that queue, with no commit issued while it is empty.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = 8,
    parameter int TAG_W    = 4,
    parameter int NRD      = 1,
    localparam int AREG_W  = $clog2(NUM_ARCH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NRD-1:0][AREG_W-1:0]       rd_idx,
    output logic [NRD-1:0][TAG_W-1:0]        rd_tag,
    input  logic                             wr_en,
    input  logic [AREG_W-1:0]                wr_idx,
    input  logic [TAG_W-1:0]                 wr_tag,
    input  logic                             load_en,
    input  logic [NUM_ARCH-1:0][TAG_W-1:0]   load_map,
    output logic [NUM_ARCH-1:0][TAG_W-1:0]   map_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= TAG_W'(i);
        end else if (load_en) begin
            map_q <= load_map;
        end else if (wr_en && wr_idx != '0) begin
            map_q[wr_idx] <= wr_tag;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_tag[p] = map_q[rd_idx[p]];
    end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int TAG_W   = $clog2(NUM_PHYS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             alloc_en,
    output logic [TAG_W-1:0]                 alloc_tag,
    output logic                             empty,
    input  logic                             rel_en,
    input  logic [TAG_W-1:0]                 rel_tag,
    input  logic                             rebuild_en,
    input  logic [NUM_ARCH-1:0][TAG_W-1:0]   ref_map,
    output logic [NUM_PHYS-1:0]              free_vec
);
    logic [NUM_PHYS-1:0] used_vec;
    logic [NUM_PHYS-1:0] take_vec;
    logic [NUM_PHYS-1:0] give_vec;

    always_comb begin
        alloc_tag = '0;
        for (int i = NUM_PHYS - 1; i >= 0; i--) begin
            if (free_vec[i]) alloc_tag = TAG_W'(i);
        end
    end

    assign empty = (free_vec == '0);

    always_comb begin
        used_vec = '0;
        for (int a = 0; a < NUM_ARCH; a++) used_vec[ref_map[a]] = 1'b1;
    end

    always_comb begin
        take_vec = '0;
        give_vec = '0;
        if (alloc_en) take_vec[alloc_tag] = 1'b1;
        if (rel_en)   give_vec[rel_tag]   = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) free_vec[i] <= (i >= NUM_ARCH);
        end else if (rebuild_en) begin
            free_vec <= ~used_vec;
        end else begin
            free_vec <= (free_vec & ~take_vec) | give_vec;
        end
    end
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int AREG_W  = $clog2(NUM_ARCH),
    localparam int TAG_W   = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [AREG_W-1:0] disp_src1,
    input  logic [AREG_W-1:0] disp_src2,
    input  logic              disp_has_dst,
    input  logic [AREG_W-1:0] disp_dst,
    output logic [TAG_W-1:0]  src1_tag,
    output logic [TAG_W-1:0]  src2_tag,
    output logic [TAG_W-1:0]  dst_tag,
    output logic [TAG_W-1:0]  prev_tag,
    output logic              stall,
    input  logic              ret_valid,
    input  logic [AREG_W-1:0] ret_dst,
    input  logic [TAG_W-1:0]  ret_tag,
    input  logic              flush
);
    import rn_pkg::*;

    rn_state_e state_q, state_d;

    logic                            recover_load;
    logic                            fl_empty;
    logic [TAG_W-1:0]                fl_tag;
    logic [NUM_PHYS-1:0]             free_vec;
    logic                            alloc_fire;
    logic                            rel_en;
    logic [TAG_W-1:0]                ret_old_tag;
    logic [2:0][AREG_W-1:0]          spec_rd_idx;
    logic [2:0][TAG_W-1:0]           spec_rd_tag;
    logic [NUM_ARCH-1:0][TAG_W-1:0]  spec_map;
    logic [NUM_ARCH-1:0][TAG_W-1:0]  rrat_map;
    logic [NUM_ARCH-1:0][TAG_W-1:0]  rrat_post;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Transitions: T_FLUSH, T_RESUME, T_REFLUSH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     state_d = flush ? ST_RECOVER : ST_RUN;
            ST_RECOVER: state_d = flush ? ST_RECOVER : ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        stall        = 1'b1;
        recover_load = 1'b0;
        unique case (state_q)
            ST_RUN:     stall = flush | fl_empty;
            ST_RECOVER: begin
                stall        = 1'b1;
                recover_load = 1'b1;
            end
            default:    stall = 1'b1;
        endcase
    end

    assign alloc_fire = disp_valid & ~stall & disp_has_dst & (disp_dst != '0);
    assign rel_en     = ret_valid & (ret_dst != '0);

    assign spec_rd_idx[0] = disp_src1;
    assign spec_rd_idx[1] = disp_src2;
    assign spec_rd_idx[2] = disp_dst;

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .NRD(3)) spec_map_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (spec_rd_idx),
        .rd_tag   (spec_rd_tag),
        .wr_en    (alloc_fire),
        .wr_idx   (disp_dst),
        .wr_tag   (fl_tag),
        .load_en  (recover_load),
        .load_map (rrat_post),
        .map_q    (spec_map)
    );

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W), .NRD(1)) rrat_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (ret_dst),
        .rd_tag   (ret_old_tag),
        .wr_en    (rel_en),
        .wr_idx   (ret_dst),
        .wr_tag   (ret_tag),
        .load_en  (1'b0),
        .load_map (rrat_map),
        .map_q    (rrat_map)
    );

    // Retirement map as it will be after this cycle's commit
    always_comb begin
        rrat_post = rrat_map;
        if (rel_en) rrat_post[ret_dst] = ret_tag;
    end

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) free_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (alloc_fire),
        .alloc_tag  (fl_tag),
        .empty      (fl_empty),
        .rel_en     (rel_en),
        .rel_tag    (ret_old_tag),
        .rebuild_en (recover_load),
        .ref_map    (rrat_post),
        .free_vec   (free_vec)
    );

    assign src1_tag = spec_rd_tag[0];
    assign src2_tag = spec_rd_tag[1];
    assign prev_tag = spec_rd_tag[2];
    assign dst_tag  = alloc_fire ? fl_tag : '0;
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int AREG_W  = $clog2(NUM_ARCH),
    localparam int TAG_W   = $clog2(NUM_PHYS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic                stall,
    input logic                disp_valid,
    input logic                disp_has_dst,
    input logic [AREG_W-1:0]   disp_dst,
    input logic [AREG_W-1:0]   disp_src1,
    input logic [TAG_W-1:0]    src1_tag,
    input logic [TAG_W-1:0]    dst_tag,
    input logic                ret_valid,
    input logic [AREG_W-1:0]   ret_dst,
    input logic [TAG_W-1:0]    ret_old_tag,
    input logic [NUM_PHYS-1:0] free_vec
);
    logic alloc_seen;
    assign alloc_seen = disp_valid && !stall && disp_has_dst && (disp_dst != '0);

    AST_FLUSH_HOLDS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> stall); // R8

    AST_ZERO_NEVER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !free_vec[0]); // R5

    AST_ZERO_SRC_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_src1 == '0) |-> (src1_tag == '0)); // R5

    AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_seen |-> free_vec[dst_tag]); // R3

    AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_seen |=> !free_vec[$past(dst_tag)]); // R3

    AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (free_vec == '0) |-> stall); // R6

    AST_COMMIT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_dst != '0) |=> free_vec[$past(ret_old_tag)]); // R7
endmodule

bind rn_rename rn_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush        (flush),
    .stall        (stall),
    .disp_valid   (disp_valid),
    .disp_has_dst (disp_has_dst),
    .disp_dst     (disp_dst),
    .disp_src1    (disp_src1),
    .src1_tag     (src1_tag),
    .dst_tag      (dst_tag),
    .ret_valid    (ret_valid),
    .ret_dst      (ret_dst),
    .ret_old_tag  (ret_old_tag),
    .free_vec     (free_vec)
);

// File: tb/rn_rename_tb_top.sv
`timescale 1ns/1ps
module rn_rename_tb_top;
    localparam int NA = 8;
    localparam int NP = 16;
    localparam int AW = $clog2(NA);
    localparam int TW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid = 1'b0;
    logic [AW-1:0] disp_src1 = '0;
    logic [AW-1:0] disp_src2 = '0;
    logic          disp_has_dst = 1'b0;
    logic [AW-1:0] disp_dst = '0;
    logic [TW-1:0] src1_tag, src2_tag, dst_tag, prev_tag;
    logic          stall;
    logic          ret_valid = 1'b0;
    logic [AW-1:0] ret_dst = '0;
    logic [TW-1:0] ret_tag = '0;
    logic          flush = 1'b0;

    always #2.5 clk = ~clk;

    rn_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP)) dut_i (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference state
    int       m_spec [NA];
    int       m_rrat [NA];
    bit [NP-1:0] m_free;
    bit       m_recov;
    int       q_arch [NP];
    int       q_tag  [NP];
    int       q_head, q_cnt;

    int g_src1, g_src2, g_dst, g_prev, g_stall;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int lowest_free(input bit [NP-1:0] f);
        for (int i = 0; i < NP; i++) if (f[i]) return i;
        return 0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NA; i++) begin m_spec[i] = i; m_rrat[i] = i; end
        for (int i = 0; i < NP; i++) m_free[i] = (i >= NA);
        m_recov = 0; q_head = 0; q_cnt = 0;
    endtask

    // One cycle: rv 0 = no commit, 1 = commit queue head, 2 = commit to register 0
    task automatic step(input int dv, input int s1, input int s2, input int hd,
                        input int d, input int rv, input int fl);
        int exp_stall, alloc, atag, r_arch, r_tag, old;
        r_arch = 0; r_tag = 0;
        if (rv == 1) begin r_arch = q_arch[q_head]; r_tag = q_tag[q_head]; end
        if (rv == 2) begin r_arch = 0; r_tag = 3; end
        disp_valid = dv[0]; disp_src1 = AW'(s1); disp_src2 = AW'(s2);
        disp_has_dst = hd[0]; disp_dst = AW'(d);
        ret_valid = (rv != 0); ret_dst = AW'(r_arch); ret_tag = TW'(r_tag);
        flush = fl[0];
        #1;
        g_src1 = src1_tag; g_src2 = src2_tag; g_dst = dst_tag;
        g_prev = prev_tag; g_stall = stall;
        exp_stall = (fl != 0 || m_recov || m_free == '0) ? 1 : 0;
        alloc = (dv != 0 && !exp_stall && hd != 0 && d != 0) ? 1 : 0;
        atag  = alloc ? lowest_free(m_free) : 0;
        chk("R6", "stall", g_stall, exp_stall);
        chk("R3", "dst_tag", g_dst, atag);
        if (dv != 0) begin
            chk("R2", "src1_tag", g_src1, m_spec[s1]);
            chk("R2", "src2_tag", g_src2, m_spec[s2]);
            chk("R3", "prev_tag", g_prev, m_spec[d]);
        end
        @(posedge clk);
        if (rv == 1) begin
            old = m_rrat[r_arch]; m_rrat[r_arch] = r_tag; m_free[old] = 1'b1;
            q_head = (q_head + 1) % NP; q_cnt--;
        end
        if (alloc != 0) begin
            m_free[atag] = 1'b0; m_spec[d] = atag;
            q_arch[(q_head + q_cnt) % NP] = d; q_tag[(q_head + q_cnt) % NP] = atag; q_cnt++;
        end
        if (m_recov) begin
            m_free = '1;
            for (int i = 0; i < NA; i++) begin m_spec[i] = m_rrat[i]; m_free[m_rrat[i]] = 1'b0; end
        end
        m_recov = fl[0];
        if (fl != 0) begin q_head = 0; q_cnt = 0; end
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int seed, dv, hd, rv, fl;
        seed = $urandom(32'h5EED_0470);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: identity maps, first allocation above the architectural range
        for (int i = 0; i < NA; i++) begin
            step(1, i, NA - 1 - i, 0, 0, 0, 0);
            chk("R1", "reset src1", g_src1, i);
            chk("R1", "reset src2", g_src2, NA - 1 - i);
        end
        // R2 pair: R1 = R2*R3 then R3 = R1+R3
        step(1, 2, 3, 1, 1, 0, 0);
        chk("R1", "first alloc", g_dst, 8);
        chk("R3", "prev of R1", g_prev, 1);
        step(1, 1, 3, 1, 3, 0, 0);
        chk("R2", "R1 source sees new tag", g_src1, 8);
        chk("R2", "R3 source sees old tag", g_src2, 3);
        chk("R3", "second alloc", g_dst, 9);
        // R4: no destination, and destination 0
        step(1, 4, 4, 0, 5, 0, 0);
        chk("R4", "no-dst alloc", g_dst, 0);
        step(1, 4, 4, 1, 0, 0, 0);
        chk("R4", "dst0 alloc", g_dst, 0);
        step(1, 4, 4, 1, 5, 0, 0);
        chk("R4", "pool untouched", g_dst, 10);
        // R5: register zero
        step(1, 0, 0, 0, 0, 0, 0);
        chk("R5", "src zero", g_src1, 0);
        chk("R5", "src zero b", g_src2, 0);
        // R6: drain the pool
        step(1, 1, 1, 1, 2, 0, 0);
        step(1, 1, 1, 1, 4, 0, 0);
        step(1, 1, 1, 1, 6, 0, 0);
        step(1, 1, 1, 1, 7, 0, 0);
        step(1, 1, 1, 1, 2, 0, 0);
        chk("R6", "last tag", g_dst, 15);
        step(1, 1, 1, 1, 4, 0, 0);
        chk("R6", "stall when empty", g_stall, 1);
        chk("R6", "no alloc when empty", g_dst, 0);
        // R7: commit frees old retirement tag 1, usable next cycle only
        step(1, 1, 1, 1, 6, 1, 0);
        chk("R7", "same-cycle stall", g_stall, 1);
        step(1, 1, 1, 1, 6, 0, 0);
        chk("R7", "freed tag allocated", g_dst, 1);
        // R10: commit to register 0 changes nothing
        step(1, 1, 1, 1, 7, 2, 0);
        step(1, 1, 1, 1, 7, 0, 0);
        chk("R10", "still empty", g_stall, 1);
        // R8 / R9: flush and recovery
        step(1, 1, 1, 1, 2, 0, 1);
        chk("R8", "flush cycle stall", g_stall, 1);
        step(1, 1, 1, 1, 2, 0, 0);
        chk("R8", "recover cycle stall", g_stall, 1);
        step(1, 1, 3, 0, 0, 0, 0);
        chk("R8", "spec copy R1", g_src1, 8);
        chk("R8", "spec copy R3", g_src2, 3);
        step(1, 1, 1, 1, 2, 0, 0);
        chk("R9", "rebuilt pool low", g_dst, 1);
        step(1, 1, 1, 1, 2, 0, 0);
        chk("R9", "rebuilt pool next", g_dst, 9);

        // random traffic
        for (int c = 0; c < 4000; c++) begin
            dv = ($urandom % 10) < 7;
            hd = ($urandom % 10) < 8;
            rv = (q_cnt > 0 && ($urandom % 10) < 4) ? 1 : 0;
            fl = (($urandom % 100) < 2) ? 1 : 0;
            step(dv, $urandom % NA, $urandom % NA, hd, $urandom % NA, rv, fl);
        end
        finish_run();
    end
endmodule